// File: doc/BRIEF.md
# Packetizing Remote Memory Bridge

This block sits beside a host processor's memory port and claims one fixed window of physical addresses. Each host access that falls inside the window is turned into a short byte packet for a remote processor that owns that memory. The block then stalls the host until the remote side answers with a reply packet. Addresses outside the window are not claimed, and the host's local memory serves them.

An outgoing packet starts with one count byte that gives the number of payload bytes that follow. The payload starts with an operation code and carries little-endian address and data fields. Replies arrive as byte streams framed by an end marker. The block checks the reply's length and code, and then either returns a word, returns zero, or flags a protocol fault. Only one request is in flight at a time. When the link is down, claimed accesses finish at once and send nothing.

Top module: `rmb_bridge`

## Requirements
- R1: `remote_sel` is high exactly when `req_addr` is at least octal 3000000 and below octal 3040000. A request outside that range sends no byte and never raises `done`.
- R2: A read sends the bytes 4, 2, then three address bytes, least significant first, built from only the low 14 bits of the address. `tx_last` marks the final byte.
- R3: A write sends the bytes 9, 1, then three address bytes built as in R2, then five data bytes, least significant first. The upper four bits of the fifth data byte are zero.
- R4: A read reply whose first byte is 3 (acknowledge) returns its bytes 2 to 6 as the word, least significant first. Only the low 36 bits are kept. Bytes the reply does not carry count as zero. `err` is low.
- R5: A read reply with code 4 (remote error) or code 5 (remote timeout) completes the read with `rdata` zero and `err` low.
- R6: A write completes with `err` low when its reply code is 3, 4 or 5.
- R7: A reply longer than 7 bytes, or one whose code is not 3, 4 or 5, completes the access with `err` high and `rdata` zero. The next access then proceeds normally. A reply of exactly 7 bytes is valid.
- R8: While `link_up` is low, a claimed access sends nothing. It completes on the next cycle with `rdata` zero and `err` low.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R10: After reset, `done`, `tx_valid` and `rx_ready` are low. `rx_ready` is never high while a request is being transmitted. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access request, held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Host physical address |
| req_wdata | input | 36 | Write word |
| link_up | input | 1 | Remote link connected |
| remote_sel | output | 1 | Address lies in the bridged window |
| done | output | 1 | Access complete (one-cycle pulse) |
| err | output | 1 | Protocol fault on the completed access |
| rdata | output | 36 | Read word, valid with `done` |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Link accepts outgoing byte |
| tx_last | output | 1 | Final byte of outgoing packet |
| rx_data | input | 8 | Incoming reply byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block accepts incoming byte |
| rx_last | input | 1 | Final byte of incoming reply |

## Verification
The bench builds the bridge with its default parameters: a 22-bit address, a 36-bit word, a 14-bit window offset and a 7-byte reply limit. With these values both window edges can be reached at addresses a test can name directly, as can the offset's all-ones pattern and the unused top nibble of the fifth data byte. The same values put a reply of exactly 7 bytes and one of 8 bytes side by side at the protocol-fault threshold. A repeating `tx_ready` pattern stalls packets in the middle, so the hold behaviour is exercised on both the count byte and the payload bytes.

// File: rtl/rmb_pkg.sv
package rmb_pkg;

    typedef enum logic [7:0] {
        OP_STORE = 8'd1,
        OP_FETCH = 8'd2,
        RP_ACK   = 8'd3,
        RP_FAIL  = 8'd4,
        RP_LATE  = 8'd5,
        OP_NUDGE = 8'd6
    } link_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_FIN
    } brg_state_e;

    typedef struct packed {
        logic [7:0] code;
        logic       overlong;
    } reply_meta_t;

    function automatic logic reply_known(input logic [7:0] c);
        return (c == RP_ACK) || (c == RP_FAIL) || (c == RP_LATE);
    endfunction

endpackage

// File: rtl/rmb_tx_framer.sv
module rmb_tx_framer #(
    parameter int MAX_LEN = 9,
    parameter int LEN_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LEN_W-1:0]        len,
    input  logic [MAX_LEN-1:0][7:0] payload,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    output logic                    tx_last,
    input  logic                    tx_ready,
    output logic                    sent
);
    logic                    active_q;
    logic [LEN_W-1:0]        idx_q;
    logic [LEN_W-1:0]        len_q;
    logic [MAX_LEN-1:0][7:0] pay_q;

    // idx 0 carries the count byte; idx k carries payload byte k-1
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            len_q    <= '0;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            len_q    <= len;
        end else if (active_q && tx_ready) begin
            if (idx_q == len_q) active_q <= 1'b0;
            else                idx_q    <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (start && !active_q) pay_q <= payload;
    end

    assign tx_valid = active_q;
    assign tx_data  = (idx_q == '0) ? 8'(len_q) : pay_q[idx_q - 1'b1];
    assign tx_last  = active_q && (idx_q == len_q);
    assign sent     = tx_last && tx_ready;

endmodule

// File: rtl/rmb_rx_parser.sv
module rmb_rx_parser
    import rmb_pkg::*;
#(
    parameter int DEPTH      = 7,
    parameter int DATA_W     = 36,
    parameter int DATA_BYTES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              pkt_done,
    output reply_meta_t       meta,
    output logic [DATA_W-1:0] data
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [7:0]       buf_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             over_q;
    logic             done_q;
    logic             accept;
    logic [DATA_BYTES*8-1:0] wide;

    assign rx_ready = enable && !done_q;
    assign accept   = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (rst || done_q) begin
            cnt_q  <= '0;
            over_q <= 1'b0;
            done_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) buf_q[i] <= 8'h00;
        end else if (accept) begin
            if (cnt_q == CNT_W'(DEPTH)) begin
                over_q <= 1'b1;
            end else begin
                buf_q[cnt_q] <= rx_data;
                cnt_q        <= cnt_q + 1'b1;
            end
            if (rx_last) done_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_word
        assign wide[8*g +: 8] = buf_q[1+g];
    end

    assign data          = wide[DATA_W-1:0];
    assign meta.code     = buf_q[0];
    assign meta.overlong = over_q;
    assign pkt_done      = done_q;

endmodule

// File: rtl/rmb_bridge.sv
module rmb_bridge
    import rmb_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 36,
    parameter int WIN_BASE   = 'o3000000,
    parameter int WIN_LIMIT  = 'o3040000,
    parameter int OFF_W      = 14,
    parameter int ADDR_BYTES = 3,
    parameter int MAX_REPLY  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              link_up,
    output logic              remote_sel,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_last
);
    localparam int DATA_BYTES = (DATA_W + 7) / 8;
    localparam int RD_LEN     = 1 + ADDR_BYTES;
    localparam int WR_LEN     = RD_LEN + DATA_BYTES;
    localparam int LEN_W      = $clog2(WR_LEN + 1);

    brg_state_e              state_q;
    logic                    wr_q;
    logic                    err_q;
    logic [DATA_W-1:0]       rdata_q;
    logic                    start;
    logic                    sent;
    logic                    pkt_done;
    reply_meta_t             meta;
    logic [DATA_W-1:0]       rx_word;
    logic [LEN_W-1:0]        pkt_len;
    logic [WR_LEN-1:0][7:0]  payload;
    logic [ADDR_BYTES*8-1:0] offset;
    logic [DATA_BYTES*8-1:0] wword;

    assign remote_sel = (req_addr >= ADDR_W'(WIN_BASE)) &&
                        (req_addr <  ADDR_W'(WIN_LIMIT));

    assign offset  = (ADDR_BYTES*8)'(req_addr[OFF_W-1:0]);
    assign wword   = (DATA_BYTES*8)'(req_wdata);
    assign pkt_len = req_write ? LEN_W'(WR_LEN) : LEN_W'(RD_LEN);

    always_comb begin
        payload    = '0;
        payload[0] = req_write ? OP_STORE : OP_FETCH;
        for (int i = 0; i < ADDR_BYTES; i++) payload[1+i]      = offset[8*i +: 8];
        for (int i = 0; i < DATA_BYTES; i++) payload[RD_LEN+i] = wword[8*i +: 8];
    end

    assign start = (state_q == ST_IDLE) && req_valid && remote_sel && link_up;

    rmb_tx_framer #(.MAX_LEN(WR_LEN), .LEN_W(LEN_W)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len      (pkt_len),
        .payload  (payload),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .sent     (sent)
    );

    rmb_rx_parser #(.DEPTH(MAX_REPLY), .DATA_W(DATA_W), .DATA_BYTES(DATA_BYTES)) u_parser (
        .clk      (clk),
        .rst      (rst),
        .enable   (state_q == ST_WAIT),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_last  (rx_last),
        .rx_ready (rx_ready),
        .pkt_done (pkt_done),
        .meta     (meta),
        .data     (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid && remote_sel) begin
                    wr_q <= req_write;
                    if (link_up) begin
                        state_q <= ST_SEND;
                    end else begin
                        err_q   <= 1'b0;
                        rdata_q <= '0;
                        state_q <= ST_FIN;
                    end
                end
                ST_SEND: if (sent) state_q <= ST_WAIT;
                ST_WAIT: if (pkt_done) begin
                    state_q <= ST_FIN;
                    if (meta.overlong || !reply_known(meta.code)) begin
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                    end else begin
                        err_q   <= 1'b0;
                        rdata_q <= (!wr_q && meta.code == RP_ACK) ? rx_word : '0;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done  = (state_q == ST_FIN);
    assign err   = err_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/rmb_bridge_chk.sv
module rmb_bridge_chk #(
    parameter int DATA_W = 36,
    parameter int RD_LEN = 4,
    parameter int WR_LEN = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              remote_sel,
    input logic              link_up,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] rdata,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic              rx_ready
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_RX_QUIET_IN_TX: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready); // R10

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        done && err |-> rdata == '0); // R7

    AST_LEAD_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data == 8'(RD_LEN) || tx_data == 8'(WR_LEN))); // R2

    AST_PKT_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(remote_sel && link_up)); // R1

endmodule

bind rmb_bridge rmb_bridge_chk #(.DATA_W(DATA_W), .RD_LEN(RD_LEN), .WR_LEN(WR_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .remote_sel (remote_sel),
    .link_up    (link_up),
    .done       (done),
    .err        (err),
    .rdata      (rdata),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_last    (tx_last),
    .rx_ready   (rx_ready)
);

// File: tb/test_rmb_bridge.sv
`timescale 1ns/1ps
module test_rmb_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, link_up = 1'b1;
    logic [21:0] req_addr = '0;
    logic [35:0] req_wdata = '0;
    logic        remote_sel, done, err;
    logic [35:0] rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic        rx_ready;

    always #2 clk = ~clk;

    rmb_bridge i_rmb_bridge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .link_up(link_up),
        .remote_sel(remote_sel), .done(done), .err(err), .rdata(rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_last(rx_last)
    );

    int n_chk = 0, n_bad = 0, phase = 0;
    string cur_req = "R10";
    logic [8:0]  exp_tx[$];
    logic [36:0] exp_res[$];
    logic [7:0]  rep_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: link byte scoreboard and completion scoreboard
    always @(negedge clk) begin
        phase++;
        tx_ready = (phase % 3 != 1);
        if (!rst) begin
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0)
                    check(0, "R1", "unexpected tx byte", {55'd0, tx_last, tx_data}, 64'd0);
                else begin
                    logic [8:0] e;
                    e = exp_tx.pop_front();
                    check({tx_last, tx_data} == e, cur_req, "tx byte {last,data}",
                          {55'd0, tx_last, tx_data}, {55'd0, e});
                end
            end
            if (done) begin
                if (exp_res.size() == 0)
                    check(0, "R1", "unexpected done", {27'd0, err, rdata}, 64'd0);
                else begin
                    logic [36:0] r;
                    r = exp_res.pop_front();
                    check({err, rdata} == r, cur_req, "completion {err,rdata}",
                          {27'd0, err, rdata}, {27'd0, r});
                end
            end
        end
    end

    task automatic access(input bit wr, input logic [21:0] a, input logic [35:0] wd,
                          input bit link, input logic [35:0] ed, input bit ee,
                          input string tag);
        bit sel;
        logic [39:0] w;
        logic [7:0] b[$];
        int k;
        cur_req = tag;
        sel = (a >= 22'o3000000) && (a < 22'o3040000);
        w = {4'b0, wd};
        if (sel && link) begin
            b.push_back(wr ? 8'd9 : 8'd4);
            b.push_back(wr ? 8'd1 : 8'd2);
            b.push_back(a[7:0]);
            b.push_back({2'b00, a[13:8]});
            b.push_back(8'h00);
            if (wr) for (int i = 0; i < 5; i++) b.push_back(w[8*i +: 8]);
            for (int i = 0; i < b.size(); i++) exp_tx.push_back({i == b.size() - 1, b[i]});
        end
        if (sel) exp_res.push_back({ee, ed});
        req_write = wr; req_addr = a; req_wdata = wd; link_up = link; req_valid = 1'b1;
        #0;
        check(remote_sel == sel, "R1", "remote_sel", {63'd0, remote_sel}, {63'd0, sel});
        if (!sel) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b0;
            return;
        end
        if (link) begin
            for (int i = 0; i < rep_q.size(); i++) begin
                rx_data = rep_q[i]; rx_valid = 1'b1; rx_last = (i == rep_q.size() - 1);
                while (!rx_ready) @(negedge clk);
                @(negedge clk);
            end
            rx_valid = 1'b0; rx_last = 1'b0;
        end else @(negedge clk);
        k = 0;
        while (!done && k < 200) begin @(negedge clk); k++; end
        if (k == 200) check(0, tag, "done never came", 64'd0, 64'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check(!done, "R10", "done is one cycle", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R10", "watchdog expired", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !tx_valid && !rx_ready, "R10", "idle after reset",
              {61'd0, done, tx_valid, rx_ready}, 64'd0);

        // R1 out of window, both sides
        access(0, 22'o2777777, '0, 1, '0, 0, "R1");
        access(1, 22'o3040000, 36'h1, 1, '0, 0, "R1");
        // R2 R4 read with acknowledge; top nibble of byte 6 dropped
        rep_q = '{8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'hF5};
        access(0, 22'o3012345, '0, 1, 36'h544332211, 0, "R2_R4");
        // R2 offset all ones at upper edge
        rep_q = '{8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        access(0, 22'o3037777, '0, 1, 36'h504030201, 0, "R2");
        // R4 short acknowledge, missing bytes read as zero
        rep_q = '{8'h03, 8'hAA};
        access(0, 22'o3000000, '0, 1, 36'h0000000AA, 0, "R4");
        // R5 remote error and timeout on read
        rep_q = '{8'h04, 8'h12, 8'h34, 8'h56, 8'h78, 8'h09};
        access(0, 22'o3000010, '0, 1, '0, 0, "R5");
        rep_q = '{8'h05};
        access(0, 22'o3000020, '0, 1, '0, 0, "R5");
        // R3 R6 writes with each accepted reply code
        rep_q = '{8'h03};
        access(1, 22'o3000001, 36'hABCDE1234, 1, '0, 0, "R3_R6");
        rep_q = '{8'h04};
        access(1, 22'o3020304, 36'hFFFFFFFFF, 1, '0, 0, "R6");
        rep_q = '{8'h05, 8'h00};
        access(1, 22'o3037777, 36'h000000001, 1, '0, 0, "R6");
        // R7 protocol faults and the 7-byte boundary
        rep_q = '{8'h06};
        access(0, 22'o3001000, '0, 1, '0, 1, "R7");
        rep_q = '{8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        access(0, 22'o3001001, '0, 1, '0, 1, "R7");
        rep_q = '{8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        access(0, 22'o3001002, '0, 1, 36'h504030201, 0, "R7");
        rep_q = '{8'h07};
        access(1, 22'o3001003, 36'h5, 1, '0, 1, "R7");
        rep_q = '{8'h03};
        access(1, 22'o3001004, 36'h6, 1, '0, 0, "R7");
        // R8 link down: nothing sent
        access(0, 22'o3000500, '0, 0, '0, 0, "R8");
        access(1, 22'o3000501, 36'h123, 0, '0, 0, "R8");

        repeat (5) @(negedge clk);
        check(exp_tx.size() == 0, "R1", "tx bytes left unsent", exp_tx.size(), 64'd0);
        check(exp_res.size() == 0, "R1", "completions missing", exp_res.size(), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule